// File: doc/BRIEF.md
# I2C Register-Access Slave for a Three-Axis Rate Sensor

This block lets an I2C master read and configure a small register set holding three 16-bit angular rate samples. It runs entirely in the system clock domain. SCL and SDA are oversampled, synchronized and de-glitched. START, repeated START and STOP are recognized from SDA edges while SCL is high. SDA is driven open-drain, as a single "pull low" enable.

The device answers to a 7-bit address. The upper six bits come from a writable address register. The lowest bit is the level of an external strap pin. In a write transfer, the byte after the address loads an internal register pointer, and later bytes go to the register it selects. A read returns the register at the pointer and then steps the pointer down by one. The step wraps from the lowest output register to the highest, so one burst fetches all three axes.

Loading the pointer with an output-register address takes a snapshot of the live sample inputs. The bytes of a burst therefore come from one instant. Setting the off bit in the control register silences the slave until the next reset.

Top module: `i2c_rate_slave`

## Requirements
- R1: After reset SDA is released, the control register (address 02h) reads 00h, the address register (address 22h) reads 0Fh, the pointer is 11h and all six output registers hold 00h.
- R2: The device address is {address register bits 5:0, strap pin}. A matching address byte is acknowledged by pulling SDA low during the ninth clock, for either value of the read/write bit (bit 0, 1 = read).
- R3: A non-matching address is not acknowledged, and every later byte up to the next START is neither acknowledged nor written.
- R4: In a write transfer the first byte after the address loads the pointer and each later byte is written to the register at the pointer; every such byte is acknowledged. Only 02h (8 bits) and 22h (bits 5:0) are writable, and every other address reads 00h.
- R5: Read data is sent MSB first. The pointer steps down by one after every byte sent, including a single-byte read, and a new read transfer continues from the stepped value.
- R6: A read at pointer 0Ch leaves the pointer at 11h.
- R7: The output registers are 0Ch X low, 0Dh X high, 0Eh Y low, 0Fh Y high, 10h Z low and 11h Z high. They take a copy of the three sample inputs only when the pointer is loaded with a value from 0Ch to 11h. At all other times they hold their value.
- R8: A master NACK after a read byte ends the transfer, and the slave leaves SDA released until the next START.
- R9: A repeated START in mid-transfer starts a new address phase.
- R10: A STOP returns the slave to idle. When control bit 4 is 1, the slave ignores every address and leaves SDA released.
- R11: Writing the address register or changing the strap pin moves the device address accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pin_i | input | 1 | Strap pin giving device address bit 0 |
| rate_x_i | input | 16 | Live X sample |
| rate_y_i | input | 16 | Live Y sample |
| rate_z_i | input | 16 | Live Z sample |

## Verification
The main path is driven with several kinds of transfer:
- Write-then-read pairs to writable, read-only and unmapped addresses. These separate a real register store from an ignored write.
- A six-byte decrementing burst that ends on a NACK. It tells a correct 0Ch-to-11h wrap from a plain decrement.
- A read with no pointer load after the sample inputs have changed. It shows whether the snapshot holds or follows the live inputs.
- Address bytes that differ only in the strap bit or in the register field, sent before and after the field is rewritten. These confirm which bits take part in the match.
- A transfer sent after the off bit is set. Its missing ACK shows that the disable works.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  localparam int BYTE_W    = 8;
  localparam int SAMPLE_W  = 16;
  localparam int N_AXES    = 3;
  localparam int DEVF_W    = 6;
  localparam logic [BYTE_W-1:0] REG_CTRL   = 8'h02;
  localparam logic [BYTE_W-1:0] REG_DEVADR = 8'h22;
  localparam logic [BYTE_W-1:0] OUT_FIRST  = 8'h0C;
  localparam logic [BYTE_W-1:0] OUT_LAST   = 8'h11;
  localparam logic [BYTE_W-1:0] PTR_RESET  = 8'h11;
  localparam logic [DEVF_W-1:0] DEVF_RESET = 6'h0F;
  localparam int OFF_BIT = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } eng_state_t;

  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    return (p == OUT_FIRST) ? OUT_LAST : p - 8'd1;
  endfunction

  function automatic logic in_out_range(input logic [BYTE_W-1:0] p);
    return (p >= OUT_FIRST) && (p <= OUT_LAST);
  endfunction
endpackage

// File: rtl/i2c_rs_filter.sv
module i2c_rs_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0]     sync_q;
  logic [LEN-1:0] hist_q;
  logic           lvl_q, lvl_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      lvl_q  <= 1'b1;
      lvl_d1 <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      hist_q <= {hist_q[LEN-2:0], sync_q[1]};
      if (&hist_q)       lvl_q <= 1'b1;
      else if (~|hist_q) lvl_q <= 1'b0;
      lvl_d1 <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~lvl_d1;
  assign fall_o = ~lvl_q & lvl_d1;
endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              ptr_load_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  eng_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, tx, ptr;
  logic              rw, first, mack;
  logic              rd_load, addr_done, addr_hit;

  assign addr_done = (state == ST_ADDR) && scl_fall_i && (cnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == dev_addr_i);
  assign rd_load   = en_i && !stop_i && !start_i && scl_fall_i &&
                     (((state == ST_ADDR_ACK) && rw) || ((state == ST_RD_ACK) && mack));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  tx <= '0;
      ptr <= PTR_RESET;  rw <= 1'b0; first <= 1'b0; mack <= 1'b0;
      sda_oe_o <= 1'b0;  ptr_load_o <= 1'b0; wr_en_o <= 1'b0;
      wr_addr_o <= '0;   wr_data_o <= '0;
    end else begin
      ptr_load_o <= 1'b0;
      wr_en_o    <= 1'b0;
      if (!en_i) begin
        state <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state <= ST_ADDR;
        cnt <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise_i) begin
              shreg <= {shreg[6:0], sda_lvl_i};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_WR_BYTE) begin
                state <= ST_WR_ACK;
                sda_oe_o <= 1'b1;
              end else if (addr_hit) begin
                state <= ST_ADDR_ACK;
                rw <= shreg[0];
                sda_oe_o <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i && !rw) begin
              state <= ST_WR_BYTE;
              first <= 1'b1;
              cnt <= '0;
              sda_oe_o <= 1'b0;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state <= ST_WR_BYTE;
              if (first) begin
                ptr <= shreg;
                ptr_load_o <= 1'b1;
                first <= 1'b0;
              end else begin
                wr_en_o <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= shreg;
              end
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall_i) begin
              if (cnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state <= ST_RD_ACK;
                cnt <= '0;
              end else begin
                tx <= {tx[6:0], 1'b0};
                sda_oe_o <= ~tx[6];
                cnt <= cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) mack <= ~sda_lvl_i;
            else if (scl_fall_i && !mack) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
        if (rd_load) begin
          tx <= rd_data_i;
          sda_oe_o <= ~rd_data_i[7];
          ptr <= ptr_step(ptr);
          cnt <= '0;
          state <= ST_RD_BYTE;
        end
      end
    end
  end

  assign ptr_o = ptr;

  // R10
  idle_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_i && en_i) |=> (state == ST_IDLE && !sda_oe_o));
  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !sda_oe_o);
  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_load && ptr == OUT_FIRST) |=> (ptr == OUT_LAST));
  // R3
  reject_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_done && !addr_hit && en_i && !start_i && !stop_i) |=> (state == ST_IDLE && !sda_oe_o));
  // R8
  drive_slot_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe_o |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD_BYTE));
endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile
  import i2c_rs_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en_i,
  input  logic [BYTE_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic                       ptr_load_i,
  input  logic [BYTE_W-1:0]          ptr_i,
  input  logic [N_AXES*SAMPLE_W-1:0] rate_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [DEVF_W-1:0]          devf_o,
  output logic                       en_o
);
  localparam int HALF = SAMPLE_W / 2;

  logic [BYTE_W-1:0]   ctrl_q;
  logic [DEVF_W-1:0]   devf_q;
  logic [SAMPLE_W-1:0] snap [N_AXES];
  logic                snap_en;
  logic [BYTE_W-1:0]   idx;

  assign snap_en = ptr_load_i && in_out_range(ptr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      devf_q <= DEVF_RESET;
    end else if (wr_en_i) begin
      if (wr_addr_i == REG_CTRL)   ctrl_q <= wr_data_i;
      if (wr_addr_i == REG_DEVADR) devf_q <= wr_data_i[DEVF_W-1:0];
    end
  end

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    always_ff @(posedge clk) begin
      if (rst)          snap[g] <= '0;
      else if (snap_en) snap[g] <= rate_i[g*SAMPLE_W +: SAMPLE_W];
    end
    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !snap_en |=> $stable(snap[g]));
  end

  assign idx = ptr_i - OUT_FIRST;

  always_comb begin
    rd_data_o = '0;
    if (ptr_i == REG_CTRL)        rd_data_o = ctrl_q;
    else if (ptr_i == REG_DEVADR) rd_data_o = {{(BYTE_W-DEVF_W){1'b0}}, devf_q};
    else if (in_out_range(ptr_i)) begin
      for (int a = 0; a < N_AXES; a++) begin
        if (idx[2:1] == a[1:0])
          rd_data_o = idx[0] ? snap[a][SAMPLE_W-1:HALF] : snap[a][HALF-1:0];
      end
    end
  end

  assign devf_o = devf_q;
  assign en_o   = ~ctrl_q[OFF_BIT];
endmodule

// File: rtl/i2c_rate_slave.sv
module i2c_rate_slave
  import i2c_rs_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic                addr_pin_i,
  input  logic [SAMPLE_W-1:0] rate_x_i,
  input  logic [SAMPLE_W-1:0] rate_y_i,
  input  logic [SAMPLE_W-1:0] rate_z_i
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_ev, stop_ev, en;
  logic [DEVF_W-1:0] devf;
  logic [BYTE_W-1:0] ptr, rd_data, wr_addr, wr_data;
  logic ptr_load, wr_en, pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= addr_pin_i;
  end

  i2c_rs_filter #(.LEN(FILT_LEN)) u_scl_flt (
    .clk(clk), .rst(rst), .pin_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_rs_filter #(.LEN(FILT_LEN)) u_sda_flt (
    .clk(clk), .rst(rst), .pin_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;

  i2c_rs_engine u_eng (
    .clk(clk), .rst(rst), .en_i(en), .sda_lvl_i(sda_lvl),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev),
    .dev_addr_i({devf, pin_q}), .rd_data_i(rd_data),
    .ptr_o(ptr), .ptr_load_o(ptr_load),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o));

  i2c_rs_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ptr_load_i(ptr_load), .ptr_i(ptr),
    .rate_i({rate_z_i, rate_y_i, rate_x_i}),
    .rd_data_o(rd_data), .devf_o(devf), .en_o(en));
endmodule

// File: tb/i2c_rate_slave_tb.sv
module i2c_rate_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic pin = 1'b0;
  logic [15:0] rx = 16'hA1B2, ry = 16'hC3D4, rz = 16'hE5F6;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_rate_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pin_i(pin), .rate_x_i(rx), .rate_y_i(ry), .rate_z_i(rz));

  // table: pointer, data written, value expected on read-back
  localparam logic [23:0] VEC [5] = '{
    {8'h02, 8'h05, 8'h05}, {8'h02, 8'hA3, 8'hA3}, {8'h22, 8'hCF, 8'h0F},
    {8'h07, 8'h5A, 8'h00}, {8'h02, 8'h00, 8'h00}};

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start; sda_m = 1; scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q); endtask
  task automatic i2c_rstart; sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q); endtask
  task automatic i2c_stop; sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q); endtask
  task automatic bit_out(logic b); sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); endtask
  task automatic bit_in(output logic b);
    sda_m = 1; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic wr_byte(logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask
  task automatic rd_byte(bit last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(last);
  endtask

  task automatic write_reg(logic [6:0] dev, logic [7:0] p, logic [7:0] d, output bit all_ack);
    bit a0, a1, a2;
    i2c_start; wr_byte({dev, 1'b0}, a0); wr_byte(p, a1); wr_byte(d, a2); i2c_stop;
    all_ack = a0 & a1 & a2;
  endtask
  task automatic read_reg(logic [6:0] dev, logic [7:0] p, output logic [7:0] d);
    bit a;
    i2c_start; wr_byte({dev, 1'b0}, a); wr_byte(p, a);
    i2c_rstart; wr_byte({dev, 1'b1}, a); rd_byte(1, d); i2c_stop;
  endtask
  task automatic read_here(logic [6:0] dev, output logic [7:0] d);
    bit a;
    i2c_start; wr_byte({dev, 1'b1}, a); rd_byte(1, d); i2c_stop;
  endtask
  task automatic probe(logic [6:0] dev, output bit ack);
    i2c_start; wr_byte({dev, 1'b0}, ack); i2c_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_b [6];
    bit ack;
    tick(5); rst = 0; tick(5);

    // R1 reset state
    chk(sda_oe == 0, "R1 sda released", sda_oe, 0);
    read_here(7'h1E, d);
    chk(d == 8'h00, "R1 output reg zero at ptr 11h", d, 0);
    read_reg(7'h1E, 8'h02, d);
    chk(d == 8'h00, "R1 ctrl reset", d, 0);
    read_reg(7'h1E, 8'h22, d);
    chk(d == 8'h0F, "R1 addr reg reset", d, 8'h0F);

    // R4 table walk
    foreach (VEC[i]) begin
      write_reg(7'h1E, VEC[i][23:16], VEC[i][15:8], ack);
      chk(ack, "R4 write acked", ack, 1);
      read_reg(7'h1E, VEC[i][23:16], d);
      chk(d == VEC[i][7:0], "R4 read-back", d, VEC[i][7:0]);
    end

    // R5 R6 R7 R9 burst across the wrap
    begin
      bit a;
      exp_b = '{8'hE5, 8'hF6, 8'hC3, 8'hD4, 8'hA1, 8'hB2};
      i2c_start; wr_byte({7'h1E, 1'b0}, a); wr_byte(8'h11, a);
      i2c_rstart; wr_byte({7'h1E, 1'b1}, a);
      chk(a, "R9 address after repeated start acked", a, 1);
      for (int k = 0; k < 6; k++) begin
        rd_byte(k == 5, d);
        chk(d == exp_b[k], "R5 R7 burst byte", d, exp_b[k]);
      end
      i2c_stop;
    end
    rx = 16'h1111; ry = 16'h2233; rz = 16'h4455;
    read_here(7'h1E, d);
    chk(d == 8'hE5, "R6 R7 wrap to 11h, snapshot held", d, 8'hE5);

    // R5 single-byte reads step the pointer
    read_reg(7'h1E, 8'h0F, d);
    chk(d == 8'h22, "R5 R7 Y high after refresh", d, 8'h22);
    read_here(7'h1E, d);
    chk(d == 8'h33, "R5 next read at 0Eh", d, 8'h33);

    // R8 NACK ends read
    begin
      bit a;
      i2c_start; wr_byte({7'h1E, 1'b1}, a); rd_byte(1, d); rd_byte(1, d); i2c_stop;
      chk(d == 8'hFF, "R8 released after NACK", d, 8'hFF);
    end

    // R2 R3 R11 addressing
    begin
      bit a0, a1, a2;
      i2c_start; wr_byte({7'h1F, 1'b0}, a0); wr_byte(8'h02, a1); wr_byte(8'h10, a2); i2c_stop;
      chk(!a0 && !a1 && !a2, "R3 no ack for foreign address", {a0, a1, a2}, 0);
    end
    read_reg(7'h1E, 8'h02, d);
    chk(d == 8'h00, "R3 ignored write", d, 0);
    pin = 1; tick(4);
    probe(7'h1F, ack); chk(ack, "R2 R11 strap 1 matches 1Fh", ack, 1);
    probe(7'h1E, ack); chk(!ack, "R11 1Eh rejected with strap 1", ack, 0);
    write_reg(7'h1F, 8'h22, 8'h20, ack);
    probe(7'h41, ack); chk(ack, "R11 new field gives 41h", ack, 1);
    probe(7'h1F, ack); chk(!ack, "R11 old address rejected", ack, 0);

    // R10 disable
    write_reg(7'h41, 8'h02, 8'h10, ack);
    chk(ack, "R10 off bit write acked", ack, 1);
    probe(7'h41, ack); chk(!ack, "R10 silent when off", ack, 0);
    rst = 1; tick(4); rst = 0; tick(4);
    probe(7'h1F, ack); chk(ack, "R1 R10 enabled after reset", ack, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule